// File: doc/BRIEF.md
# Debug Communications Mailbox

This block passes single 32-bit words in both directions between an on-chip processor and an external debugger whose clock has no relation to the processor clock. Each direction has its own one-word holding register and a full flag. The processor deposits a word for the debugger into the outgoing register and collects words from the debugger out of the incoming register. The debugger does the opposite through a parallel port in its own clock domain.

The processor reaches the block through a small indexed register port. Index 0 returns a read-only status word, and index 1 is the data window. A write at index 1 fills the outgoing register, and a read at index 1 returns the incoming register. The status word carries a fixed version code in its top four bits and the two full flags in its lowest bits. Every flag is set in one clock domain and cleared in the other. The events cross as toggles through two-flop synchronizers, so each side sees a delayed but exact view of both flags. Two level interrupts tell the processor that the outgoing slot is free or that an incoming word is waiting. Either side can therefore run on polling or on interrupts.

Top module: `dbg_mailbox`

## Requirements
- R1: After both resets, both flags are clear, both data registers hold zero, the status word reads 32'h1000_0000, irqTxFree is 1 and irqRxPend is 0.
- R2: A processor read at index 0 returns a status word with bits 31:28 equal to 4'b0001, bits 27:2 equal to zero, bit 1 equal to the outgoing-full flag and bit 0 equal to the incoming-full flag.
- R3: A processor write at index 1 while the outgoing-full flag is clear loads the word and sets the flag in the processor view at the next processor edge. A debugger read (dbgRdEn while dbgOutFull is 1) clears dbgOutFull at the next debugger edge.
- R4: A debugger write while dbgInFull is 0 loads the incoming register and sets dbgInFull at the next debugger edge. A processor read at index 1 while the incoming-full flag is set clears that flag at the next processor edge.
- R5: Each flag change made on one side appears in the other side's view within SYNC_STAGES+1 cycles of the receiving clock. This covers bit 1 and bit 0 of the status word on the processor side, and dbgOutFull and dbgInFull on the debugger side.
- R6: A processor read at index 1 returns the incoming register, and dbgRdData always shows the outgoing register. Reads at indices other than 0 and 1 return zero. Writes at any index other than 1 change nothing.
- R7: irqTxFree is 1 exactly while the processor view of the outgoing-full flag is clear. irqRxPend is 1 exactly while the processor view of the incoming-full flag is set.
- R8: A processor write while the outgoing-full flag is set, or a debugger write while dbgInFull is 1, is ignored. The stored word and all flags stay unchanged.
- R9: A read of an empty register returns its last contents and changes no flag, on either side.
- R10: Words streamed in both directions at the same time, with both sides polling their flags, arrive complete and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpuClk | input | 1 | Processor clock |
| cpuRstN | input | 1 | Processor-domain asynchronous reset, active low |
| cpuIdx | input | IDX_W | Processor register index (0 is status, 1 is data) |
| cpuWrEn | input | 1 | Processor write strobe |
| cpuWrData | input | DATA_W | Processor write data |
| cpuRdEn | input | 1 | Processor read strobe; a read at index 1 consumes the incoming word |
| cpuRdData | output | DATA_W | Processor read data for the selected index (combinational) |
| irqTxFree | output | 1 | Level interrupt: outgoing register is empty |
| irqRxPend | output | 1 | Level interrupt: incoming word is waiting |
| dbgClk | input | 1 | Debugger clock |
| dbgRstN | input | 1 | Debugger-domain asynchronous reset, active low |
| dbgWrEn | input | 1 | Debugger write strobe into the incoming register |
| dbgWrData | input | DATA_W | Debugger write data |
| dbgRdEn | input | 1 | Debugger read strobe; consumes the outgoing word |
| dbgRdData | output | DATA_W | Contents of the outgoing register |
| dbgOutFull | output | 1 | Debugger view of the outgoing-full flag |
| dbgInFull | output | 1 | Debugger view of the incoming-full flag |

## Verification
A flag change made in its own domain is due at the first edge of that domain after the access. The bench checks it at the following falling edge, for example the processor-side full flag after a processor write. A change that crosses domains needs SYNC_STAGES edges of the receiving clock, and the phase between the two clocks shifts throughout the run. The bench therefore polls the receiving view at falling edges and reports a failure if the view has not changed within SYNC_STAGES+1 receiving cycles. The data outputs and the status word are combinational, so the bench samples them one nanosecond after it drives the index, always before the next rising edge.

// File: rtl/dbg_mailbox_pkg.sv
`timescale 1ns/1ps
package dbg_mailbox_pkg;
  localparam int VER_W = 4;
  localparam logic [VER_W-1:0] VERSION_CODE = 4'b0001;
  localparam int IDX_STATUS = 0;
  localparam int IDX_DATA = 1;
  localparam int BIT_TX_FULL = 1;
  localparam int BIT_RX_FULL = 0;

  typedef struct packed {
    logic loadOut;   // processor domain: capture outgoing word
    logic loadIn;    // debugger domain: capture incoming word
  } mbx_strobe_t;
endpackage

// File: rtl/mbx_sync.sv
`timescale 1ns/1ps
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_ctrl.sv
`timescale 1ns/1ps
module mbx_ctrl
  import dbg_mailbox_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic        cpuClk,
  input  logic        cpuRstN,
  input  logic [IDX_W-1:0] cpuIdx,
  input  logic        cpuWrEn,
  input  logic        cpuRdEn,
  input  logic        dbgClk,
  input  logic        dbgRstN,
  input  logic        dbgWrEn,
  input  logic        dbgRdEn,
  output mbx_strobe_t strobe,
  output logic        cpuTxFull,
  output logic        cpuRxFull,
  output logic        dbgTxFull,
  output logic        dbgRxFull
);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(IDX_DATA);

  // Toggle registers: one per event source
  logic txTog;      // processor wrote outgoing word
  logic rxAckTog;   // processor consumed incoming word
  logic rxTog;      // debugger wrote incoming word
  logic txAckTog;   // debugger consumed outgoing word

  logic txAckInCpu, rxTogInCpu, txTogInDbg, rxAckInDbg;

  mbx_sync #(.STAGES(SYNC_STAGES)) u_syncTxAck (
    .clk(cpuClk), .rstN(cpuRstN), .d(txAckTog), .q(txAckInCpu));
  mbx_sync #(.STAGES(SYNC_STAGES)) u_syncRxTog (
    .clk(cpuClk), .rstN(cpuRstN), .d(rxTog), .q(rxTogInCpu));
  mbx_sync #(.STAGES(SYNC_STAGES)) u_syncTxTog (
    .clk(dbgClk), .rstN(dbgRstN), .d(txTog), .q(txTogInDbg));
  mbx_sync #(.STAGES(SYNC_STAGES)) u_syncRxAck (
    .clk(dbgClk), .rstN(dbgRstN), .d(rxAckTog), .q(rxAckInDbg));

  assign cpuTxFull = txTog ^ txAckInCpu;
  assign cpuRxFull = rxTogInCpu ^ rxAckTog;
  assign dbgTxFull = txTogInDbg ^ txAckTog;
  assign dbgRxFull = rxTog ^ rxAckInDbg;

  logic cpuDataSel, cpuLoad, cpuTake, dbgLoad, dbgTake;
  assign cpuDataSel = (cpuIdx == DATA_IDX);
  assign cpuLoad    = cpuWrEn & cpuDataSel & ~cpuTxFull;
  assign cpuTake    = cpuRdEn & cpuDataSel & cpuRxFull;
  assign dbgLoad    = dbgWrEn & ~dbgRxFull;
  assign dbgTake    = dbgRdEn & dbgTxFull;

  always_ff @(posedge cpuClk or negedge cpuRstN) begin
    if (!cpuRstN) begin
      txTog    <= 1'b0;
      rxAckTog <= 1'b0;
    end else begin
      if (cpuLoad) txTog    <= ~txTog;
      if (cpuTake) rxAckTog <= ~rxAckTog;
    end
  end

  always_ff @(posedge dbgClk or negedge dbgRstN) begin
    if (!dbgRstN) begin
      rxTog    <= 1'b0;
      txAckTog <= 1'b0;
    end else begin
      if (dbgLoad) rxTog    <= ~rxTog;
      if (dbgTake) txAckTog <= ~txAckTog;
    end
  end

  always_comb begin
    strobe = '0;
    strobe.loadOut = cpuLoad;
    strobe.loadIn  = dbgLoad;
  end
endmodule

// File: rtl/mbx_datapath.sv
`timescale 1ns/1ps
module mbx_datapath
  import dbg_mailbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W = 2
) (
  input  logic              cpuClk,
  input  logic              cpuRstN,
  input  logic              dbgClk,
  input  logic              dbgRstN,
  input  mbx_strobe_t       strobe,
  input  logic [IDX_W-1:0]  cpuIdx,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] dbgWrData,
  input  logic              txFull,
  input  logic              rxFull,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [DATA_W-1:0] outWord,
  output logic [DATA_W-1:0] inWord
);
  localparam logic [IDX_W-1:0] STATUS_IDX = IDX_W'(IDX_STATUS);
  localparam logic [IDX_W-1:0] DATA_IDX   = IDX_W'(IDX_DATA);

  logic [DATA_W-1:0] outReg, inReg, statusWord;

  always_ff @(posedge cpuClk or negedge cpuRstN) begin
    if (!cpuRstN)           outReg <= '0;
    else if (strobe.loadOut) outReg <= cpuWrData;
  end

  always_ff @(posedge dbgClk or negedge dbgRstN) begin
    if (!dbgRstN)           inReg <= '0;
    else if (strobe.loadIn) inReg <= dbgWrData;
  end

  always_comb begin
    statusWord = '0;
    statusWord[DATA_W-1 -: VER_W] = VERSION_CODE;
    statusWord[BIT_TX_FULL] = txFull;
    statusWord[BIT_RX_FULL] = rxFull;
  end

  always_comb begin
    if (cpuIdx == STATUS_IDX)    cpuRdData = statusWord;
    else if (cpuIdx == DATA_IDX) cpuRdData = inReg;
    else                         cpuRdData = '0;
  end

  assign outWord = outReg;
  assign inWord  = inReg;
endmodule

// File: rtl/dbg_mailbox.sv
`timescale 1ns/1ps
module dbg_mailbox
  import dbg_mailbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              cpuClk,
  input  logic              cpuRstN,
  input  logic [IDX_W-1:0]  cpuIdx,
  input  logic              cpuWrEn,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuRdEn,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              irqTxFree,
  output logic              irqRxPend,
  input  logic              dbgClk,
  input  logic              dbgRstN,
  input  logic              dbgWrEn,
  input  logic [DATA_W-1:0] dbgWrData,
  input  logic              dbgRdEn,
  output logic [DATA_W-1:0] dbgRdData,
  output logic              dbgOutFull,
  output logic              dbgInFull
);
  mbx_strobe_t       strobe;
  logic              cpuTxFull, cpuRxFull, dbgTxFull, dbgRxFull;
  logic [DATA_W-1:0] outWord, inWord;

  mbx_ctrl #(.IDX_W(IDX_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .cpuClk(cpuClk), .cpuRstN(cpuRstN), .cpuIdx(cpuIdx),
    .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn),
    .dbgClk(dbgClk), .dbgRstN(dbgRstN),
    .dbgWrEn(dbgWrEn), .dbgRdEn(dbgRdEn),
    .strobe(strobe),
    .cpuTxFull(cpuTxFull), .cpuRxFull(cpuRxFull),
    .dbgTxFull(dbgTxFull), .dbgRxFull(dbgRxFull));

  mbx_datapath #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .cpuClk(cpuClk), .cpuRstN(cpuRstN),
    .dbgClk(dbgClk), .dbgRstN(dbgRstN),
    .strobe(strobe), .cpuIdx(cpuIdx),
    .cpuWrData(cpuWrData), .dbgWrData(dbgWrData),
    .txFull(cpuTxFull), .rxFull(cpuRxFull),
    .cpuRdData(cpuRdData), .outWord(outWord), .inWord(inWord));

  assign irqTxFree  = ~cpuTxFull;
  assign irqRxPend  = cpuRxFull;
  assign dbgRdData  = outWord;
  assign dbgOutFull = dbgTxFull;
  assign dbgInFull  = dbgRxFull;
endmodule

// File: rtl/dbg_mailbox_chk.sv
`timescale 1ns/1ps
module dbg_mailbox_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W = 2
) (
  input logic              cpuClk,
  input logic              cpuRstN,
  input logic [IDX_W-1:0]  cpuIdx,
  input logic              cpuWrEn,
  input logic [DATA_W-1:0] cpuWrData,
  input logic              cpuRdEn,
  input logic [DATA_W-1:0] cpuRdData,
  input logic              irqTxFree,
  input logic              irqRxPend,
  input logic              dbgClk,
  input logic              dbgRstN,
  input logic              dbgWrEn,
  input logic [DATA_W-1:0] dbgWrData,
  input logic              dbgRdEn,
  input logic              dbgOutFull,
  input logic              dbgInFull,
  input logic [DATA_W-1:0] outWord,
  input logic [DATA_W-1:0] inWord
);
  localparam logic [IDX_W-1:0] IDX0 = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX1 = IDX_W'(1);

  // R2: status layout matches the interrupt-visible flag state
  assert_status_layout_R2: assert property (@(posedge cpuClk) disable iff (!cpuRstN)
    (cpuIdx == IDX0) |-> (cpuRdData[DATA_W-1 -: 4] == 4'b0001) &&
                         (cpuRdData[DATA_W-5:2] == '0) &&
                         (cpuRdData[1] == !irqTxFree) && (cpuRdData[0] == irqRxPend));

  // R3: accepted processor write captures the word and marks it full
  assert_cpu_load_R3: assert property (@(posedge cpuClk) disable iff (!cpuRstN)
    (cpuWrEn && cpuIdx == IDX1 && irqTxFree) |=> (!irqTxFree && outWord == $past(cpuWrData)));

  // R4: processor consumption clears the pending flag
  assert_cpu_take_R4: assert property (@(posedge cpuClk) disable iff (!cpuRstN)
    (cpuRdEn && cpuIdx == IDX1 && irqRxPend) |=> !irqRxPend);

  // R8: processor write into a full slot leaves the word alone
  assert_cpu_wr_ignored_R8: assert property (@(posedge cpuClk) disable iff (!cpuRstN)
    (!irqTxFree) |=> $stable(outWord));

  // R4: accepted debugger write captures the word and marks it full
  assert_dbg_load_R4: assert property (@(posedge dbgClk) disable iff (!dbgRstN)
    (dbgWrEn && !dbgInFull) |=> (dbgInFull && inWord == $past(dbgWrData)));

  // R3: debugger consumption clears its view of the outgoing flag
  assert_dbg_take_R3: assert property (@(posedge dbgClk) disable iff (!dbgRstN)
    (dbgRdEn && dbgOutFull) |=> !dbgOutFull);

  // R8: debugger write into a full slot leaves the word alone
  assert_dbg_wr_ignored_R8: assert property (@(posedge dbgClk) disable iff (!dbgRstN)
    (dbgWrEn && dbgInFull) |=> $stable(inWord));
endmodule

bind dbg_mailbox dbg_mailbox_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .cpuClk(cpuClk), .cpuRstN(cpuRstN), .cpuIdx(cpuIdx), .cpuWrEn(cpuWrEn),
  .cpuWrData(cpuWrData), .cpuRdEn(cpuRdEn), .cpuRdData(cpuRdData),
  .irqTxFree(irqTxFree), .irqRxPend(irqRxPend),
  .dbgClk(dbgClk), .dbgRstN(dbgRstN), .dbgWrEn(dbgWrEn), .dbgWrData(dbgWrData),
  .dbgRdEn(dbgRdEn), .dbgOutFull(dbgOutFull), .dbgInFull(dbgInFull),
  .outWord(outWord), .inWord(inWord));

// File: tb/dbg_mailbox_bench.sv
`timescale 1ns/1ps
module dbg_mailbox_bench;
  localparam int DATA_W = 32;
  localparam int IDX_W = 2;
  localparam int SYNC_STAGES = 2;
  localparam int WAIT_MAX = SYNC_STAGES + 1;
  localparam int STREAM_N = 16;
  localparam logic [31:0] IDLE_STATUS = 32'h1000_0000;

  logic cpuClk = 1'b0, dbgClk = 1'b0;
  logic cpuRstN = 1'b0, dbgRstN = 1'b0;
  logic [IDX_W-1:0]  cpuIdx = '0;
  logic              cpuWrEn = 1'b0, cpuRdEn = 1'b0;
  logic [DATA_W-1:0] cpuWrData = '0;
  logic [DATA_W-1:0] cpuRdData;
  logic              irqTxFree, irqRxPend;
  logic              dbgWrEn = 1'b0, dbgRdEn = 1'b0;
  logic [DATA_W-1:0] dbgWrData = '0;
  logic [DATA_W-1:0] dbgRdData;
  logic              dbgOutFull, dbgInFull;

  int testCount = 0;
  int failCount = 0;

  always #5 cpuClk = ~cpuClk;       // 100 MHz
  always #8.5 dbgClk = ~dbgClk;     // unrelated debugger clock

  dbg_mailbox #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SYNC_STAGES(SYNC_STAGES)) u_dbg_mailbox (
    .cpuClk(cpuClk), .cpuRstN(cpuRstN), .cpuIdx(cpuIdx), .cpuWrEn(cpuWrEn),
    .cpuWrData(cpuWrData), .cpuRdEn(cpuRdEn), .cpuRdData(cpuRdData),
    .irqTxFree(irqTxFree), .irqRxPend(irqRxPend),
    .dbgClk(dbgClk), .dbgRstN(dbgRstN), .dbgWrEn(dbgWrEn), .dbgWrData(dbgWrData),
    .dbgRdEn(dbgRdEn), .dbgRdData(dbgRdData),
    .dbgOutFull(dbgOutFull), .dbgInFull(dbgInFull));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic [IDX_W-1:0] idx, input logic [31:0] d);
    @(negedge cpuClk);
    cpuIdx = idx; cpuWrData = d; cpuWrEn = 1'b1;
    @(negedge cpuClk);
    cpuWrEn = 1'b0; cpuIdx = '0;
  endtask

  task automatic cpuRead(input logic [IDX_W-1:0] idx, output logic [31:0] d);
    @(negedge cpuClk);
    cpuIdx = idx; cpuRdEn = 1'b1;
    #1 d = cpuRdData;
    @(negedge cpuClk);
    cpuRdEn = 1'b0; cpuIdx = '0;
  endtask

  task automatic cpuStatus(output logic [31:0] s);
    @(negedge cpuClk);
    cpuIdx = '0;
    #1 s = cpuRdData;
  endtask

  task automatic dbgWrite(input logic [31:0] d);
    @(negedge dbgClk);
    dbgWrData = d; dbgWrEn = 1'b1;
    @(negedge dbgClk);
    dbgWrEn = 1'b0;
  endtask

  task automatic dbgRead(output logic [31:0] d);
    @(negedge dbgClk);
    d = dbgRdData; dbgRdEn = 1'b1;
    @(negedge dbgClk);
    dbgRdEn = 1'b0;
  endtask

  // Poll a processor status bit until it reaches val; returns whether it did within WAIT_MAX cycles
  task automatic waitCpuBit(input int b, input logic val, output bit ok);
    logic [31:0] s;
    ok = 1'b0;
    for (int i = 0; i < WAIT_MAX; i++) begin
      cpuStatus(s);
      if (s[b] == val) begin ok = 1'b1; break; end
    end
  endtask

  task automatic waitDbgFlag(input bit outSide, input logic val, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < WAIT_MAX; i++) begin
      @(negedge dbgClk);
      if ((outSide ? dbgOutFull : dbgInFull) == val) begin ok = 1'b1; break; end
    end
  endtask

  task automatic t_reset();
    logic [31:0] s;
    cpuStatus(s);
    check(s == IDLE_STATUS, "R1 status after reset", s, IDLE_STATUS);
    check(s[31:28] == 4'b0001 && s[27:2] == '0, "R2 version and reserved field", s, IDLE_STATUS);
    check(irqTxFree == 1'b1 && irqRxPend == 1'b0, "R1 interrupts after reset",
          {30'd0, irqTxFree, irqRxPend}, 32'd2);
    check(!dbgOutFull && !dbgInFull, "R1 debugger flags after reset",
          {30'd0, dbgOutFull, dbgInFull}, 32'd0);
    check(dbgRdData == '0, "R1 outgoing register reset", dbgRdData, 32'd0);
    cpuRead(IDX_W'(1), s);
    check(s == '0, "R1 incoming register reset", s, 32'd0);
  endtask

  task automatic t_cpu_to_dbg();
    logic [31:0] s, d;
    bit ok;
    cpuWrite(IDX_W'(1), 32'hCAFE_0001);
    #1 s = cpuRdData;
    check(s[1] == 1'b1, "R3 W set next processor edge", s, IDLE_STATUS | 32'd2);
    check(irqTxFree == 1'b0, "R7 irqTxFree drops when full", {31'd0, irqTxFree}, 32'd0);
    waitDbgFlag(1'b1, 1'b1, ok);
    check(ok, "R5 dbgOutFull rises within sync window", {31'd0, dbgOutFull}, 32'd1);
    check(dbgRdData == 32'hCAFE_0001, "R6 dbgRdData shows outgoing word", dbgRdData, 32'hCAFE_0001);
    dbgRead(d);
    check(!dbgOutFull, "R3 debugger read clears dbgOutFull", {31'd0, dbgOutFull}, 32'd0);
    waitCpuBit(1, 1'b0, ok);
    check(ok, "R5 processor W clears within sync window", {31'd0, ok}, 32'd1);
    check(irqTxFree == 1'b1, "R7 irqTxFree returns when empty", {31'd0, irqTxFree}, 32'd1);
  endtask

  task automatic t_dbg_to_cpu();
    logic [31:0] s, d;
    bit ok;
    dbgWrite(32'h0BAD_F00D);
    check(dbgInFull == 1'b1, "R4 dbgInFull set next debugger edge", {31'd0, dbgInFull}, 32'd1);
    waitCpuBit(0, 1'b1, ok);
    check(ok, "R5 processor R sets within sync window", {31'd0, ok}, 32'd1);
    check(irqRxPend == 1'b1, "R7 irqRxPend while word waits", {31'd0, irqRxPend}, 32'd1);
    cpuRead(IDX_W'(1), d);
    check(d == 32'h0BAD_F00D, "R6 index 1 returns incoming word", d, 32'h0BAD_F00D);
    #1 s = cpuRdData;
    check(s[0] == 1'b0 && irqRxPend == 1'b0, "R4 processor read clears R", s, IDLE_STATUS);
    waitDbgFlag(1'b0, 1'b0, ok);
    check(ok, "R5 dbgInFull clears within sync window", {31'd0, dbgInFull}, 32'd0);
  endtask

  task automatic t_ignored();
    logic [31:0] s, d;
    bit ok;
    cpuWrite(IDX_W'(1), 32'h1111_1111);
    cpuWrite(IDX_W'(1), 32'h2222_2222);
    waitDbgFlag(1'b1, 1'b1, ok);
    check(dbgRdData == 32'h1111_1111, "R8 processor write while full ignored", dbgRdData, 32'h1111_1111);
    dbgRead(d);
    waitCpuBit(1, 1'b0, ok);
    check(ok, "R8 W clears after single consume", {31'd0, ok}, 32'd1);
    dbgWrite(32'h3333_3333);
    dbgWrite(32'h4444_4444);
    waitCpuBit(0, 1'b1, ok);
    cpuRead(IDX_W'(1), d);
    check(d == 32'h3333_3333, "R8 debugger write while full ignored", d, 32'h3333_3333);
    waitDbgFlag(1'b0, 1'b0, ok);
    check(ok, "R8 R clears after single consume", {31'd0, dbgInFull}, 32'd0);
  endtask

  task automatic t_empty_reads();
    logic [31:0] s, d;
    cpuRead(IDX_W'(1), d);
    check(d == 32'h3333_3333, "R9 empty incoming read returns last word", d, 32'h3333_3333);
    repeat (4) @(negedge dbgClk);
    check(!dbgInFull, "R9 empty processor read leaves dbgInFull", {31'd0, dbgInFull}, 32'd0);
    dbgRead(d);
    check(d == 32'h1111_1111, "R9 empty outgoing read returns last word", d, 32'h1111_1111);
    repeat (4) @(negedge cpuClk);
    cpuStatus(s);
    check(s == IDLE_STATUS, "R9 empty reads change no flag", s, IDLE_STATUS);
    check(!dbgOutFull, "R9 empty debugger read leaves dbgOutFull", {31'd0, dbgOutFull}, 32'd0);
  endtask

  task automatic t_other_idx();
    logic [31:0] s, d;
    cpuRead(IDX_W'(2), d);
    check(d == '0, "R6 index 2 reads zero", d, 32'd0);
    cpuRead(IDX_W'(3), d);
    check(d == '0, "R6 index 3 reads zero", d, 32'd0);
    cpuWrite(IDX_W'(0), 32'hDEAD_0000);
    cpuWrite(IDX_W'(2), 32'hDEAD_0002);
    repeat (4) @(negedge dbgClk);
    check(dbgRdData == 32'h1111_1111 && !dbgOutFull, "R6 writes off index 1 ignored",
          dbgRdData, 32'h1111_1111);
    cpuStatus(s);
    check(s == IDLE_STATUS, "R6 status unchanged by stray writes", s, IDLE_STATUS);
  endtask

  task automatic t_stream();
    fork
      begin : cpuSide
        int sent = 0, got = 0;
        logic [31:0] st;
        while (sent < STREAM_N || got < STREAM_N) begin
          @(negedge cpuClk);
          cpuWrEn = 1'b0; cpuRdEn = 1'b0; cpuIdx = '0;
          #1 st = cpuRdData;
          if (!st[1] && sent < STREAM_N) begin
            cpuIdx = IDX_W'(1);
            cpuWrData = 32'hA500_0000 + 32'(sent * 7);
            cpuWrEn = 1'b1;
            sent++;
          end else if (st[0] && got < STREAM_N) begin
            cpuIdx = IDX_W'(1);
            cpuRdEn = 1'b1;
            #1 check(cpuRdData == (32'h5E00_0000 ^ 32'(got * 13)), "R10 debugger-to-processor order",
                     cpuRdData, 32'h5E00_0000 ^ 32'(got * 13));
            got++;
          end
        end
        @(negedge cpuClk);
        cpuWrEn = 1'b0; cpuRdEn = 1'b0; cpuIdx = '0;
      end
      begin : dbgSide
        int sent = 0, got = 0;
        while (sent < STREAM_N || got < STREAM_N) begin
          @(negedge dbgClk);
          dbgWrEn = 1'b0; dbgRdEn = 1'b0;
          if (dbgOutFull && got < STREAM_N) begin
            check(dbgRdData == 32'hA500_0000 + 32'(got * 7), "R10 processor-to-debugger order",
                  dbgRdData, 32'hA500_0000 + 32'(got * 7));
            dbgRdEn = 1'b1;
            got++;
          end else if (!dbgInFull && sent < STREAM_N) begin
            dbgWrData = 32'h5E00_0000 ^ 32'(sent * 13);
            dbgWrEn = 1'b1;
            sent++;
          end
        end
        @(negedge dbgClk);
        dbgWrEn = 1'b0; dbgRdEn = 1'b0;
      end
    join
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge cpuClk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge cpuClk);
    cpuRstN = 1'b1;
    dbgRstN = 1'b1;
    repeat (2) @(negedge dbgClk);
    t_reset();
    t_cpu_to_dbg();
    t_dbg_to_cpu();
    t_ignored();
    t_empty_reads();
    t_other_idx();
    t_stream();
    repeat (6) @(negedge cpuClk);
    begin
      logic [31:0] s;
      cpuStatus(s);
      check(s == IDLE_STATUS && !dbgOutFull && !dbgInFull, "R10 mailbox drained after stream",
            s, IDLE_STATUS);
    end
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule